// File: doc/BRIEF.md
# TLB Miss Refill-State Loader

When a translation lookup misses, system software needs a prepared set of assist registers before it can refill the TLB. This block captures that state. On a one-cycle miss strobe it builds six assist registers from four sources: a defaults word, the missed effective address, the address-space context and the process-ID context. It also forms a two-bit syndrome. All outputs change together on the clock edge that samples the strobe. Between misses they hold their values.

The block keeps a round-robin victim-way pointer. Each miss records the current pointer as the entry to replace, advances the pointer modulo a power-of-two way count, and records the advanced value as the next victim. The block does not write the TLB.

The entry tag is chosen from one of two contexts. With the external context selected, the external ID is both the tag and the search ID. Otherwise a field of the defaults word picks one of three process IDs for the tag, and process ID 0 is always the search ID.

Top module: `tlbm_loader`

## Requirements
- R1: While rst_ni is low, every output reads zero. The victim pointer restarts at 0, so the first miss after reset reports entry 0 and next victim 1.
- R2: After a miss, the following fields are copied from dflt_i. slot_o[1:0] takes dflt_i[1:0] (table select). tag_o[11:8] takes dflt_i[11:8] (size code n, meaning a 1024 << n byte page). page_o[4:0] takes dflt_i[20:16] (cache attribute bits). rpn_lo_o and rpn_hi_o read zero.
- R3: The address space is chosen by access type. For acc_i = 2 (fetch) it is ir_space_i. For any other access it is ext_space_i when ext_en_i is high, and dat_space_i otherwise. The chosen space is written to both tag_o[12] and search_o[0].
- R4: After a miss, tag_o[31] (valid) is 1 and page_o[31:12] holds ea_i[31:12].
- R5: With ext_en_i low, dflt_i[25:24] picks the tag written to tag_o[29:16]: 0 selects pid0_i, 1 selects pid1_i, 2 selects pid2_i, and 3 gives zero. search_o[29:16] holds pid0_i.
- R6: With ext_en_i high, ext_pid_i is written to both tag_o[29:16] and search_o[29:16].
- R7: slot_o[17:16] (entry select) takes the current victim pointer. The pointer then advances by one modulo WAYS, and slot_o[25:24] (next victim) takes the advanced value.
- R8: After a miss, syndrome_o[0] is 1 exactly when acc_i = 1 (store), and syndrome_o[1] equals ext_en_i.
- R9: Outputs change only on the clock edge that samples miss_i high. With miss_i low they hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_i | input | 1 | Miss strobe, one cycle per miss |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| ea_i | input | 32 | Missed effective address |
| ir_space_i | input | 1 | Instruction address-space bit |
| dat_space_i | input | 1 | Data address-space bit |
| pid0_i | input | 14 | Process ID 0 |
| pid1_i | input | 14 | Process ID 1 |
| pid2_i | input | 14 | Process ID 2 |
| ext_en_i | input | 1 | Access uses the external ID context |
| ext_space_i | input | 1 | Address space of the external context |
| ext_pid_i | input | 14 | External ID |
| dflt_i | input | 32 | Defaults word |
| slot_o | output | 32 | Table select, entry select, next victim |
| tag_o | output | 32 | Valid, tag, space, size code |
| page_o | output | 32 | Page number and attribute bits |
| rpn_lo_o | output | 32 | Low real page number, cleared |
| search_o | output | 32 | Search ID and search space |
| rpn_hi_o | output | 32 | High real page number, cleared |
| syndrome_o | output | 2 | Store flag, external-context flag |

## Verification
The assertions assume that miss_i is a single-cycle strobe, sampled at a rising edge while reset is released. They also assume that the inputs belonging to a miss are stable when miss_i is sampled. The stimulus sets every input on the falling edge, raises the strobe for exactly one cycle, and checks the outputs on the next falling edge. A hold phase then changes every context input with the strobe low to show that nothing leaks through. The vector walk covers all four tag-select codes, both context modes and every access type. It runs through two full wraps of the victim pointer.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 32;
  localparam int PID_W   = 14;
  localparam int EPN_LSB = 12;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  // defaults word layout
  localparam int DEF_TSEL_LSB = 0;
  localparam int DEF_TSEL_W   = 2;
  localparam int DEF_SIZE_LSB = 8;
  localparam int DEF_SIZE_W   = 4;
  localparam int DEF_ATTR_LSB = 16;
  localparam int DEF_ATTR_W   = 5;
  localparam int DEF_TSRC_LSB = 24;

  // slot register
  localparam int SLOT_TSEL_LSB = 0;
  localparam int SLOT_ESEL_LSB = 16;
  localparam int SLOT_NV_LSB   = 24;

  // tag register
  localparam int TAG_VALID_BIT = 31;
  localparam int TAG_TID_LSB   = 16;
  localparam int TAG_SPACE_BIT = 12;
  localparam int TAG_SIZE_LSB  = 8;

  // page register
  localparam int PAGE_ATTR_LSB = 0;

  // search register
  localparam int SRCH_SPACE_BIT = 0;
  localparam int SRCH_PID_LSB   = 16;

  // syndrome
  localparam int SYN_STORE_BIT = 0;
  localparam int SYN_EXT_BIT   = 1;
  localparam int SYN_W         = 2;

  typedef enum logic [1:0] {
    TSRC_PID0 = 2'd0,
    TSRC_PID1 = 2'd1,
    TSRC_PID2 = 2'd2,
    TSRC_ZERO = 2'd3
  } tsrc_e;
endpackage

// File: rtl/tlbm_ctx.sv
module tlbm_ctx
  import tlbm_pkg::*;
#(
  parameter int PID_BITS = PID_W
) (
  input  logic [1:0]          acc_i,
  input  logic                ir_space_i,
  input  logic                dat_space_i,
  input  logic                ext_en_i,
  input  logic                ext_space_i,
  input  logic [PID_BITS-1:0] ext_pid_i,
  input  logic [PID_BITS-1:0] pid0_i,
  input  logic [PID_BITS-1:0] pid1_i,
  input  logic [PID_BITS-1:0] pid2_i,
  input  logic [1:0]          tsrc_i,
  output logic                space_o,
  output logic [PID_BITS-1:0] tag_o,
  output logic [PID_BITS-1:0] spid_o
);
  logic is_fetch;
  logic [PID_BITS-1:0] own_tag;

  assign is_fetch = (acc_e'(acc_i) == ACC_FETCH);

  // fetch always takes the instruction space, even in external context
  always_comb begin
    if (is_fetch)      space_o = ir_space_i;
    else if (ext_en_i) space_o = ext_space_i;
    else               space_o = dat_space_i;
  end

  always_comb begin
    unique case (tsrc_e'(tsrc_i))
      TSRC_PID0: own_tag = pid0_i;
      TSRC_PID1: own_tag = pid1_i;
      TSRC_PID2: own_tag = pid2_i;
      default:   own_tag = '0;
    endcase
  end

  assign tag_o  = ext_en_i ? ext_pid_i : own_tag;
  assign spid_o = ext_en_i ? ext_pid_i : pid0_i;
endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WAY_W-1:0] cur_o,
  output logic [WAY_W-1:0] nxt_o
);
  logic [WAY_W-1:0] ptr_q;

  generate
    if (WAYS > 1) begin : g_multi
      // WAYS is a power of two, so the counter width wraps on its own
      assign nxt_o = ptr_q + WAY_W'(1);
    end else begin : g_single
      assign nxt_o = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= nxt_o;
  end

  assign cur_o = ptr_q;

  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (cur_o == ((WAYS > 1) ? WAY_W'($past(cur_o) + 1'b1) : '0)));
  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cur_o));
endmodule

// File: rtl/tlbm_loader.sv
module tlbm_loader
  import tlbm_pkg::*;
#(
  parameter int WAYS     = 4,
  parameter int PID_BITS = PID_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_i,
  input  logic [1:0]          acc_i,
  input  logic [ADDR_W-1:0]   ea_i,
  input  logic                ir_space_i,
  input  logic                dat_space_i,
  input  logic [PID_BITS-1:0] pid0_i,
  input  logic [PID_BITS-1:0] pid1_i,
  input  logic [PID_BITS-1:0] pid2_i,
  input  logic                ext_en_i,
  input  logic                ext_space_i,
  input  logic [PID_BITS-1:0] ext_pid_i,
  input  logic [REG_W-1:0]    dflt_i,
  output logic [REG_W-1:0]    slot_o,
  output logic [REG_W-1:0]    tag_o,
  output logic [REG_W-1:0]    page_o,
  output logic [REG_W-1:0]    rpn_lo_o,
  output logic [REG_W-1:0]    search_o,
  output logic [REG_W-1:0]    rpn_hi_o,
  output logic [SYN_W-1:0]    syndrome_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int EPN_W = ADDR_W - EPN_LSB;

  logic                space;
  logic [PID_BITS-1:0] tag_id;
  logic [PID_BITS-1:0] srch_id;
  logic [WAY_W-1:0]    vic_cur;
  logic [WAY_W-1:0]    vic_nxt;

  logic [REG_W-1:0] slot_d, tag_d, page_d, search_d;
  logic [SYN_W-1:0] syn_d;
  logic [REG_W-1:0] slot_q, tag_q, page_q, search_q;
  logic [SYN_W-1:0] syn_q;

  logic unused_bits;
  assign unused_bits = ^{ea_i[EPN_LSB-1:0], dflt_i[7:2], dflt_i[15:12],
                         dflt_i[23:21], dflt_i[31:26]};

  tlbm_ctx #(.PID_BITS(PID_BITS)) u_ctx (
    .acc_i       (acc_i),
    .ir_space_i  (ir_space_i),
    .dat_space_i (dat_space_i),
    .ext_en_i    (ext_en_i),
    .ext_space_i (ext_space_i),
    .ext_pid_i   (ext_pid_i),
    .pid0_i      (pid0_i),
    .pid1_i      (pid1_i),
    .pid2_i      (pid2_i),
    .tsrc_i      (dflt_i[DEF_TSRC_LSB +: 2]),
    .space_o     (space),
    .tag_o       (tag_id),
    .spid_o      (srch_id)
  );

  tlbm_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (miss_i),
    .cur_o  (vic_cur),
    .nxt_o  (vic_nxt)
  );

  always_comb begin
    slot_d = '0;
    slot_d[SLOT_TSEL_LSB +: DEF_TSEL_W] = dflt_i[DEF_TSEL_LSB +: DEF_TSEL_W];
    slot_d[SLOT_ESEL_LSB +: WAY_W]      = vic_cur;
    slot_d[SLOT_NV_LSB +: WAY_W]        = vic_nxt;

    tag_d = '0;
    tag_d[TAG_VALID_BIT]                = 1'b1;
    tag_d[TAG_TID_LSB +: PID_BITS]      = tag_id;
    tag_d[TAG_SPACE_BIT]                = space;
    tag_d[TAG_SIZE_LSB +: DEF_SIZE_W]   = dflt_i[DEF_SIZE_LSB +: DEF_SIZE_W];

    page_d = '0;
    page_d[EPN_LSB +: EPN_W]            = ea_i[EPN_LSB +: EPN_W];
    page_d[PAGE_ATTR_LSB +: DEF_ATTR_W] = dflt_i[DEF_ATTR_LSB +: DEF_ATTR_W];

    search_d = '0;
    search_d[SRCH_SPACE_BIT]            = space;
    search_d[SRCH_PID_LSB +: PID_BITS]  = srch_id;

    syn_d = '0;
    syn_d[SYN_STORE_BIT] = (acc_e'(acc_i) == ACC_STORE);
    syn_d[SYN_EXT_BIT]   = ext_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      tag_q    <= '0;
      page_q   <= '0;
      search_q <= '0;
      syn_q    <= '0;
    end else if (miss_i) begin
      slot_q   <= slot_d;
      tag_q    <= tag_d;
      page_q   <= page_d;
      search_q <= search_d;
      syn_q    <= syn_d;
    end
  end

  assign slot_o     = slot_q;
  assign tag_o      = tag_q;
  assign page_o     = page_q;
  assign search_o   = search_q;
  assign syndrome_o = syn_q;
  // real page number halves are cleared on every miss and never set here
  assign rpn_lo_o   = '0;
  assign rpn_hi_o   = '0;

  a_r4_valid_epn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> tag_o[TAG_VALID_BIT] &&
               (page_o[EPN_LSB +: EPN_W] == $past(ea_i[EPN_LSB +: EPN_W])));
  a_r3_space_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> (tag_o[TAG_SPACE_BIT] == search_o[SRCH_SPACE_BIT]));
  a_r5_search_pid0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !ext_en_i) |=> (search_o[SRCH_PID_LSB +: PID_BITS] == $past(pid0_i)));
  a_r6_ext_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && ext_en_i) |=>
      (tag_o[TAG_TID_LSB +: PID_BITS] == $past(ext_pid_i)) &&
      (search_o[SRCH_PID_LSB +: PID_BITS] == $past(ext_pid_i)));
  a_r8_syndrome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> (syndrome_o[SYN_STORE_BIT] == ($past(acc_i) == 2'd1)) &&
               (syndrome_o[SYN_EXT_BIT] == $past(ext_en_i)));
  a_r7_esel_nv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> (slot_o[SLOT_NV_LSB +: WAY_W] ==
                ((WAYS > 1) ? WAY_W'(slot_o[SLOT_ESEL_LSB +: WAY_W] + 1'b1) : '0)));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> $stable(slot_o) && $stable(tag_o) && $stable(page_o) &&
                $stable(search_o) && $stable(syndrome_o));
endmodule

// File: tb/tlbm_loader_tb.sv
module tlbm_loader_tb;
  typedef struct packed {
    logic [1:0]  acc;
    logic        ir;
    logic        ds;
    logic        ext;
    logic        ext_sp;
    logic [1:0]  tsrc;
    logic [31:0] ea;
    logic [13:0] etag;
    logic        esp;
  } vec_t;

  localparam int NV = 8;
  localparam logic [13:0] P0 = 14'h0011, P1 = 14'h0222, P2 = 14'h3333, PX = 14'h1ABC;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h1234_5678, P0,    1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 32'hABCD_E123, P1,    1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_1FFF, P2,    1'b1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 32'h8000_0000, 14'h0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 32'h5555_5AAA, PX,    1'b1},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 32'hDEAD_B000, PX,    1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0BAD_F00D, PX,    1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF, P0,    1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_i = 1'b0;
  logic [1:0]  acc_i = '0;
  logic [31:0] ea_i = '0;
  logic        ir_space_i = 1'b0, dat_space_i = 1'b0;
  logic [13:0] pid0_i = P0, pid1_i = P1, pid2_i = P2, ext_pid_i = PX;
  logic        ext_en_i = 1'b0, ext_space_i = 1'b0;
  logic [31:0] dflt_i = '0;
  logic [31:0] slot_o, tag_o, page_o, rpn_lo_o, search_o, rpn_hi_o;
  logic [1:0]  syndrome_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  tlbm_loader u_dut (
    .clk_i, .rst_ni, .miss_i, .acc_i, .ea_i, .ir_space_i, .dat_space_i,
    .pid0_i, .pid1_i, .pid2_i, .ext_en_i, .ext_space_i, .ext_pid_i, .dflt_i,
    .slot_o, .tag_o, .page_o, .rpn_lo_o, .search_o, .rpn_hi_o, .syndrome_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt_of(input logic [1:0] tsrc);
    return 32'h2 | (32'h5 << 8) | (32'h15 << 16) | (32'(tsrc) << 24);
  endfunction

  logic [31:0] e_slot, e_tag, e_page, e_srch;
  logic [1:0]  e_syn;

  task automatic expect_vec(input vec_t v, input int esel);
    e_slot = 32'h2 | (32'(esel % 4) << 16) | (32'((esel + 1) % 4) << 24);
    e_tag  = (32'h1 << 31) | (32'(v.etag) << 16) | (32'(v.esp) << 12) | (32'h5 << 8);
    e_page = (v.ea & 32'hFFFF_F000) | 32'h15;
    e_srch = (32'(v.ext ? PX : P0) << 16) | 32'(v.esp);
    e_syn  = {v.ext, v.acc == 2'd1};
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    acc_i = v.acc; ir_space_i = v.ir; dat_space_i = v.ds;
    ext_en_i = v.ext; ext_space_i = v.ext_sp; ea_i = v.ea;
    dflt_i = dflt_of(v.tsrc); miss_i = 1'b1;
    @(negedge clk_i);
    miss_i = 1'b0;
  endtask

  task automatic check_all(input string tagname);
    chk({tagname, " R2 R7 slot"}, slot_o, e_slot);
    chk({tagname, " R3 R4 R5 R6 tag"}, tag_o, e_tag);
    chk({tagname, " R2 R4 page"}, page_o, e_page);
    chk({tagname, " R3 R5 R6 search"}, search_o, e_srch);
    chk({tagname, " R8 syndrome"}, 32'(syndrome_o), 32'(e_syn));
    chk({tagname, " R2 rpn_lo"}, rpn_lo_o, 32'h0);
    chk({tagname, " R2 rpn_hi"}, rpn_hi_o, 32'h0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 slot reset", slot_o, 0);
    chk("R1 tag reset", tag_o, 0);
    chk("R1 page reset", page_o, 0);
    chk("R1 search reset", search_o, 0);
    chk("R1 syndrome reset", 32'(syndrome_o), 0);
    rst_ni = 1'b1;

    // table walk; R7 pointer wraps twice
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      expect_vec(VECS[i], i);
      check_all($sformatf("vec%0d", i));
    end

    // R9: inputs change with miss low, outputs hold
    @(negedge clk_i);
    ea_i = 32'h0F0F_0F0F; acc_i = 2'd1; ext_en_i = 1'b1; ir_space_i = 1'b1;
    dat_space_i = 1'b0; pid0_i = 14'h2AAA; dflt_i = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk_i);
    check_all("R9 hold");
    pid0_i = P0;

    // R1: asynchronous reset mid run, pointer restarts
    rst_ni = 1'b0;
    #1;
    chk("R1 async slot", slot_o, 0);
    chk("R1 async tag", tag_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(VECS[0]);
    expect_vec(VECS[0], 0);
    check_all("R1 R7 restart");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule